// File: doc/BRIEF.md
# Alignment-Aware Burst Decomposer

This block turns one memory transfer request into a series of burst commands for a 64-bit-wide memory port. A request carries a byte address and a byte count. The block converts both into 64-bit word units. It then issues bursts one at a time until the whole word range is covered.

Each burst takes the largest power-of-two length, from 2 up to 64 words, that meets two conditions:

- the current word address is a multiple of that length;
- the length does not exceed the words still owed.

When neither condition allows 2 words, a single-word transfer is issued. Bursts at a poorly aligned start are therefore short. As the address reaches coarser boundaries, the bursts grow again, which keeps the number of commands low.

Requests enter through a valid/ready pair, and commands leave through another. A one-cycle completion pulse marks the end of each request.

Top module: `burst_decomposer`

## Requirements
- R1: The word address is the byte address shifted right by three, so the three low address bits are discarded. The word count is the byte count divided by eight and rounded up.
- R2: Each command's length is 2 to the power `cmd_log2`, with `cmd_log2` in the range 0 to 6, so every length is one of 1, 2, 4, 8, 16, 32 or 64 words.
- R3: The word address of every command is a whole multiple of that command's length.
- R4: No command's length exceeds the words of the request not yet covered.
- R5: The length chosen is the largest value from 2 to 64 words that meets both R3 and R4. When no such value exists, the length is 1 word.
- R6: Commands are contiguous. Each one starts where the previous one ended, and together they cover exactly the request's word count.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr` and `cmd_log2` hold their values.
- R8: `done` is high for exactly one cycle, the cycle after the last command of a request is accepted, and `cmd_valid` is low in that cycle.
- R9: A request whose word count is zero produces no command. `done` rises in the cycle after that request is accepted.
- R10: `req_ready` is high only while no request is in progress and reset has been released. `req_ready` and `cmd_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken when high together with req_valid |
| req_addr | input | ADDR_W | Byte start address |
| req_bytes | input | CNT_W | Byte count |
| cmd_valid | output | 1 | Burst command offered |
| cmd_ready | input | 1 | Burst command taken when high together with cmd_valid |
| cmd_addr | output | ADDR_W-3 | Word address of the burst |
| cmd_log2 | output | 3 | Base-2 logarithm of the burst length in words |
| done | output | 1 | One-cycle pulse after a request is finished |

## Verification
The assertions rely on the consumer following the handshake. A command stays in place only because its state is frozen until `cmd_ready` arrives, so the consumer must not expect a command to be withdrawn. The assertions also assume that requests arrive only through `req_ready`.

The stimulus respects both assumptions. It changes inputs only between clock edges, stalls `cmd_ready` at random, and holds each request steady until it is taken. It covers zero-length and single-word requests, odd and coarsely aligned start addresses, unaligned byte addresses, and long transfers.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} bdc_state_e;
  localparam int unsigned BYTES_PER_WORD_LOG = 3;
endpackage

// File: rtl/bdc_word_conv.sv
module bdc_word_conv #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned WADDR_W = ADDR_W - bdc_pkg::BYTES_PER_WORD_LOG,
  localparam int unsigned WCNT_W  = CNT_W - 2
) (
  input  logic [ADDR_W-1:0]  byte_addr,
  input  logic [CNT_W-1:0]   byte_cnt,
  output logic [WADDR_W-1:0] word_addr,
  output logic [WCNT_W-1:0]  word_cnt,
  output logic               is_empty
);
  logic [CNT_W:0] rounded;

  always_comb begin
    word_addr = WADDR_W'(byte_addr >> bdc_pkg::BYTES_PER_WORD_LOG);
    rounded   = {1'b0, byte_cnt} + (CNT_W+1)'(7);
    word_cnt  = WCNT_W'(rounded >> bdc_pkg::BYTES_PER_WORD_LOG);
    is_empty  = (byte_cnt == '0);
  end
endmodule

// File: rtl/bdc_size_pick.sv
module bdc_size_pick #(
  parameter int unsigned WADDR_W = 29,
  parameter int unsigned WCNT_W  = 14,
  parameter int unsigned MAX_LOG = 6,
  localparam int unsigned LOG_W  = $clog2(MAX_LOG + 1)
) (
  input  logic [WADDR_W-1:0] cur_addr,
  input  logic [WCNT_W-1:0]  left_words,
  output logic [LOG_W-1:0]   pick_log2
);
  logic [MAX_LOG:1] fits;

  for (genvar k = 1; k <= MAX_LOG; k++) begin : g_fit
    assign fits[k] = (cur_addr[k-1:0] == '0) && (left_words >= WCNT_W'(2 ** k));
  end

  always_comb begin
    pick_log2 = '0;
    for (int k = 1; k <= MAX_LOG; k++) begin
      if (fits[k]) pick_log2 = LOG_W'(k);
    end
  end
endmodule

// File: rtl/burst_decomposer.sv
module burst_decomposer #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MAX_LOG = 6,
  localparam int unsigned WADDR_W = ADDR_W - bdc_pkg::BYTES_PER_WORD_LOG,
  localparam int unsigned WCNT_W  = CNT_W - 2,
  localparam int unsigned LOG_W   = $clog2(MAX_LOG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [CNT_W-1:0]   req_bytes,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [WADDR_W-1:0] cmd_addr,
  output logic [LOG_W-1:0]   cmd_log2,
  output logic               done
);
  import bdc_pkg::*;

  logic [1:0]         rst_sync_q;
  logic               run_ok;
  bdc_state_e         state_q, state_d;
  logic [WADDR_W-1:0] addr_q, addr_d;
  logic [WCNT_W-1:0]  rem_q, rem_d;
  logic               load_en;
  logic               done_q, done_d;
  logic [WADDR_W-1:0] in_waddr;
  logic [WCNT_W-1:0]  in_words;
  logic               in_empty;
  logic [WCNT_W-1:0]  size_w;
  logic               take_req, take_cmd, last_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run_ok = rst_sync_q[1];

  bdc_word_conv #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_conv (
    .byte_addr(req_addr), .byte_cnt(req_bytes),
    .word_addr(in_waddr), .word_cnt(in_words), .is_empty(in_empty)
  );

  bdc_size_pick #(.WADDR_W(WADDR_W), .WCNT_W(WCNT_W), .MAX_LOG(MAX_LOG)) u_pick (
    .cur_addr(addr_q), .left_words(rem_q), .pick_log2(cmd_log2)
  );

  assign req_ready = run_ok && (state_q == ST_IDLE);
  assign cmd_valid = (state_q == ST_BUSY);
  assign cmd_addr  = addr_q;
  assign done      = done_q;
  assign size_w    = WCNT_W'(1) << cmd_log2;
  assign take_req  = req_valid && req_ready;
  assign take_cmd  = cmd_valid && cmd_ready;
  assign last_cmd  = (rem_q == size_w);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    load_en = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (take_req) begin
          if (in_empty || in_words == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_BUSY;
            addr_d  = in_waddr;
            rem_d   = in_words;
            load_en = 1'b1;
          end
        end
      end
      ST_BUSY: begin
        if (take_cmd) begin
          addr_d  = addr_q + WADDR_W'(size_w);
          rem_d   = rem_q - size_w;
          load_en = 1'b1;
          if (last_cmd) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_log2));

  assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_addr & WADDR_W'(size_w - WCNT_W'(1))) == '0));

  assert_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (size_w <= rem_q));

  assert_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !last_cmd |=>
      cmd_valid && (cmd_addr == $past(cmd_addr) + WADDR_W'($past(size_w))));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && cmd_valid));
endmodule

// File: tb/burst_decomposer_tb_top.sv
module burst_decomposer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int WADDR_W = ADDR_W - 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, cmd_valid, cmd_ready, done;
  logic [ADDR_W-1:0]  req_addr;
  logic [CNT_W-1:0]   req_bytes;
  logic [WADDR_W-1:0] cmd_addr;
  logic [2:0]         cmd_log2;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_decomposer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_log2(cmd_log2), .done(done)
  );

  // pending descriptors
  logic [ADDR_W-1:0] pend_addr[$];
  logic [CNT_W-1:0]  pend_bytes[$];
  // expected command stream of the active request
  logic [WADDR_W-1:0] exp_addr[$];
  int                 exp_log[$];
  bit exp_busy = 0;
  bit exp_done = 0;
  int stall_pct = 0;
  int gap_pct = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R1, R5: behavioural expansion of one request
  task automatic expand(input logic [ADDR_W-1:0] ba, input logic [CNT_W-1:0] bc);
    longint a = longint'(ba) / 8;
    longint rem = (longint'(bc) + 7) / 8;
    while (rem > 0) begin
      longint s = 64;
      int lg = 6;
      while (s > 1 && ((a % s) != 0 || s > rem)) begin
        s = s / 2;
        lg--;
      end
      exp_addr.push_back(WADDR_W'(a));
      exp_log.push_back(lg);
      a = (a + s) % (longint'(1) << WADDR_W);
      rem -= s;
    end
  endtask

  task automatic one_cycle();
    bit nd;
    @(negedge clk);
    chk(req_ready == !exp_busy, "R10 req_ready", req_ready, !exp_busy);
    chk(cmd_valid == exp_busy, "R6 cmd_valid", cmd_valid, exp_busy);
    chk(done == exp_done, "R8/R9 done", done, exp_done);
    if (exp_busy && cmd_valid) begin
      chk(cmd_addr == exp_addr[0], "R3/R6 cmd_addr", cmd_addr, exp_addr[0]);
      chk(int'(cmd_log2) == exp_log[0], "R2/R5 cmd_log2", cmd_log2, exp_log[0]);
    end
    req_valid = 1'b0;
    if (pend_addr.size() > 0 && ($urandom_range(99) >= gap_pct)) begin
      req_valid = 1'b1;
      req_addr  = pend_addr[0];
      req_bytes = pend_bytes[0];
    end
    cmd_ready = ($urandom_range(99) >= stall_pct);
    nd = 0;
    if (!exp_busy && req_valid) begin
      expand(pend_addr[0], pend_bytes[0]);
      void'(pend_addr.pop_front());
      void'(pend_bytes.pop_front());
      if (exp_addr.size() == 0) nd = 1;
      else exp_busy = 1;
    end else if (exp_busy && cmd_ready) begin
      void'(exp_addr.pop_front());
      void'(exp_log.pop_front());
      if (exp_addr.size() == 0) begin
        exp_busy = 0;
        nd = 1;
      end
    end
    exp_done = nd;
  endtask

  task automatic drain();
    while (pend_addr.size() > 0 || exp_busy || exp_done) one_cycle();
    one_cycle();
  endtask

  task automatic push(input longint ba, input longint bc);
    pend_addr.push_back(ADDR_W'(ba));
    pend_bytes.push_back(CNT_W'(bc));
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    cmd_ready = 1'b0;
    req_addr = '0;
    req_bytes = '0;
    repeat (4) @(negedge clk);
    chk(!req_ready && !cmd_valid && !done, "R10 reset quiet",
        {req_ready, cmd_valid, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 zero length, twice back to back
    push(64, 0); push(8, 0); drain();
    // R1 single byte -> one word; R5 odd fallback
    push(24, 1); drain();
    // R5 word 8, 32 words: 8, 16, 8
    push(64, 256); drain();
    // R1 low address bits dropped, 9 bytes -> 2 words
    push(5, 9); drain();
    // R4 odd address with short remainder
    push(8 * 3, 8 * 5); drain();
    // R5 long transfer growing back to 64
    push(8 * 3, 8000); drain();
    // R7 stalls
    stall_pct = 60;
    push(8 * 7, 8 * 130); push(8 * 128, 8 * 64); drain();
    // random mix
    gap_pct = 30;
    for (int i = 0; i < 300; i++) begin
      push($urandom, $urandom_range(4096));
    end
    drain();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule